// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi/Lo Result Registers

This block is a sequential integer multiply and divide engine that owns the two result registers of an integer pipeline: Hi and Lo. A command carries a 6-bit function code and two 32-bit operands. Multiplication leaves the full 64-bit product split across Hi (upper word) and Lo (lower word). Division leaves the quotient in Lo and the remainder in Hi. A signed and an unsigned form of each operation is selected by the function code. Each operation runs one bit per cycle: shift-and-add for the product and restoring subtraction for the quotient.

Commands enter on a valid/ready pair. `cmd_ready` is high exactly when the unit is idle. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The unit never queues a command: anything presented while `cmd_ready` is low is dropped, so a sender that needs the command carried out must hold `cmd_valid` until it sees ready. Results are read back through a separate read port, selected by function code. A read request made while an operation is in flight is refused with `rd_stall`, and the requester must repeat it. Once the unit is idle, read data is combinational from the stored registers.

Top module: `muldiv_hilo`

## Requirements
- R1: Function code 0x18 multiplies the operands as two's complement numbers and stores the 64-bit product, upper half in Hi and lower half in Lo.
- R2: Function code 0x19 multiplies the operands as unsigned magnitudes and stores the 64-bit product, upper half in Hi and lower half in Lo.
- R3: Function code 0x1a divides as two's complement numbers. The quotient is truncated toward zero and goes to Lo. The remainder takes the sign of the dividend and goes to Hi. The case 0x80000000 divided by 0xFFFFFFFF gives Lo = 0x80000000 and Hi = 0.
- R4: Function code 0x1b divides as unsigned magnitudes. The quotient goes to Lo and the remainder to Hi.
- R5: A divide with a zero divisor, signed or unsigned, completes in the normal time with Lo = 0xFFFFFFFF and Hi equal to the dividend.
- R6: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high and the code is one of 0x18, 0x19, 0x1a, 0x1b. `busy` then stays high for exactly 33 cycles, starting with the cycle after that edge. `cmd_ready` is the inverse of `busy`. Hi and Lo take their new values on the edge where `busy` falls.
- R7: While `busy` is low, `rd_data` shows Hi when `rd_funct` is 0x10, shows Lo when it is 0x12, and shows zero for any other code, in the same cycle. Hi and Lo hold their values until the next operation completes.
- R8: `rd_stall` is high when `rd_req` is high and `busy` is high, and low otherwise.
- R9: A command presented while `busy` is high is ignored: the running operation finishes with the result of the command taken first.
- R10: A command with any other code is taken without effect: `busy` stays low and Hi and Lo keep their values.
- R11: After reset, Hi and Lo are zero, `busy` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_funct | input | 6 | Operation code (0x18, 0x19, 0x1a, 0x1b) |
| cmd_a | input | 32 | First operand (multiplicand or dividend) |
| cmd_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in flight |
| rd_req | input | 1 | Read request for Hi or Lo |
| rd_funct | input | 6 | Read selector: 0x10 Hi, 0x12 Lo |
| rd_stall | output | 1 | Read refused while busy |
| rd_data | output | 32 | Selected register value |

## Verification
A wrong step counter or a wrong state in the sequencer shows at once as a `busy` window that is not 33 cycles long, and it is seen on the first operation. A wrong iteration in either datapath, a lost sign flag or a wrong zero-divisor case shows only when Hi or Lo is read back after `busy` falls. That read happens one cycle after completion, so every operation is compared against a value computed independently with 64-bit arithmetic. A wrongly accepted command, made while busy or carrying an unknown code, either changes the length of the busy window or corrupts the next read back.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [5:0] {
    FN_MFHI  = 6'h10,
    FN_MFLO  = 6'h12,
    FN_MULT  = 6'h18,
    FN_MULTU = 6'h19,
    FN_DIV   = 6'h1a,
    FN_DIVU  = 6'h1b
  } funct_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } state_e;

  // Per-operation flags captured at acceptance
  typedef struct packed {
    logic is_div;    // divide rather than multiply
    logic neg_wide;  // negate the 64-bit product
    logic neg_lo;    // negate the quotient
    logic neg_hi;    // negate the remainder
  } op_flags_t;

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  logic      cmd_known,
  input  op_flags_t flags_in,
  output logic      cmd_ready,
  output logic      busy,
  output logic      load,
  output logic      step,
  output logic      finish,
  output op_flags_t flags_q
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  state_e        state_q;
  logic [CW-1:0] cnt_q;

  assign busy      = (state_q != ST_IDLE);
  assign cmd_ready = !busy;
  assign load      = cmd_valid && cmd_ready && cmd_known;
  assign step      = (state_q == ST_RUN);
  assign finish    = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          flags_q <= flags_in;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] acc_hi_q, acc_lo_q, mcand_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_hi_q} + (acc_lo_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      mcand_q  <= '0;
    end else if (load) begin
      acc_hi_q <= '0;
      acc_lo_q <= mplier;
      mcand_q  <= mcand;
    end else if (step) begin
      {acc_hi_q, acc_lo_q} <= {sum, acc_lo_q[W-1:1]};
    end
  end

  assign prod = {acc_hi_q, acc_lo_q};

endmodule

// File: rtl/div_restore.sv
module div_restore #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W-1:0] rem_q, quot_q, dsr_q;
  logic [W:0]   shifted, diff;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quot_q[W-1]};
    diff    = shifted - {1'b0, dsr_q};
    fits    = (shifted >= {1'b0, dsr_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quot_q <= '0;
      dsr_q  <= '0;
    end else if (load) begin
      rem_q  <= '0;
      quot_q <= dividend;
      dsr_q  <= divisor;
    end else if (step) begin
      rem_q  <= fits ? diff[W-1:0] : shifted[W-1:0];
      quot_q <= {quot_q[W-2:0], fits};
    end
  end

  assign quot = quot_q;
  assign rem  = rem_q;

endmodule

// File: rtl/hilo_bank.sv
module hilo_bank
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_hi,
  input  logic [W-1:0] wr_lo,
  input  logic [5:0]   rd_funct,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= wr_hi;
      lo_q <= wr_lo;
    end
  end

  always_comb begin
    unique case (rd_funct)
      FN_MFHI: rd_data = hi_q;
      FN_MFLO: rd_data = lo_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [5:0]   cmd_funct,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  input  logic         rd_req,
  input  logic [5:0]   rd_funct,
  output logic         rd_stall,
  output logic [W-1:0] rd_data
);
  logic           is_signed, is_known, is_div_cmd, sign_mix;
  logic [W-1:0]   a_mag, b_mag;
  op_flags_t      flags_in, flags_q;
  logic           load, step, finish;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0]   quot, rem;
  logic [W-1:0]   wr_hi, wr_lo;

  // Command decode and operand magnitudes
  always_comb begin
    is_signed  = (cmd_funct == FN_MULT) || (cmd_funct == FN_DIV);
    is_div_cmd = (cmd_funct == FN_DIV)  || (cmd_funct == FN_DIVU);
    is_known   = is_signed || is_div_cmd || (cmd_funct == FN_MULTU);
    a_mag      = (is_signed && cmd_a[W-1]) ? -cmd_a : cmd_a;
    b_mag      = (is_signed && cmd_b[W-1]) ? -cmd_b : cmd_b;
    sign_mix   = is_signed && (cmd_a[W-1] ^ cmd_b[W-1]);
    flags_in.is_div   = is_div_cmd;
    flags_in.neg_wide = sign_mix;
    flags_in.neg_lo   = sign_mix && (cmd_b != '0);
    flags_in.neg_hi   = is_signed && cmd_a[W-1];
  end

  muldiv_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_known (is_known),
    .flags_in  (flags_in),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .load      (load),
    .step      (step),
    .finish    (finish),
    .flags_q   (flags_q)
  );

  mul_shift_add #(.W(W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load && !is_div_cmd),
    .step   (step && !flags_q.is_div),
    .mcand  (a_mag),
    .mplier (b_mag),
    .prod   (prod)
  );

  div_restore #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load && is_div_cmd),
    .step     (step && flags_q.is_div),
    .dividend (a_mag),
    .divisor  (b_mag),
    .quot     (quot),
    .rem      (rem)
  );

  // Sign restoration applied on the completion cycle
  always_comb begin
    prod_fix = flags_q.neg_wide ? -prod : prod;
    if (flags_q.is_div) begin
      wr_lo = flags_q.neg_lo ? -quot : quot;
      wr_hi = flags_q.neg_hi ? -rem  : rem;
    end else begin
      wr_hi = prod_fix[2*W-1:W];
      wr_lo = prod_fix[W-1:0];
    end
  end

  hilo_bank #(.W(W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (finish),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .rd_funct (rd_funct),
    .rd_data  (rd_data)
  );

  assign rd_stall = rd_req && busy;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [5:0]   cmd_funct,
  input logic         busy,
  input logic         rd_req,
  input logic [5:0]   rd_funct,
  input logic         rd_stall,
  input logic [W-1:0] rd_data
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] run_len;
  logic          known;

  assign known = (cmd_funct == 6'h18) || (cmd_funct == 6'h19) ||
                 (cmd_funct == 6'h1a) || (cmd_funct == 6'h1b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R6: an accepted command starts a run
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && known |=> busy);

  // R6: every run lasts W+1 cycles
  p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == LW'(W + 1));

  // R10: an unknown code never starts a run
  p_unknown_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !known |=> !busy);

  // R8: a stalled read coincides with a refused command port
  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> !cmd_ready);

  // R7: read data holds while idle with an unchanged selector
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && rd_req && $past(rd_req) &&
    rd_funct == $past(rd_funct) |-> $stable(rd_data));

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_funct (cmd_funct),
  .busy      (busy),
  .rd_req    (rd_req),
  .rd_funct  (rd_funct),
  .rd_stall  (rd_stall),
  .rd_data   (rd_data)
);

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/1ps
module sim_muldiv_hilo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [5:0]  cmd_funct = 0;
  logic [31:0] cmd_a = 0, cmd_b = 0;
  logic        busy;
  logic        rd_req = 0;
  logic [5:0]  rd_funct = 0;
  logic        rd_stall;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  muldiv_hilo u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_funct(cmd_funct), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rd_req(rd_req), .rd_funct(rd_funct), .rd_stall(rd_stall), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (f)
      6'h18: model = sa * sb;
      6'h19: model = ua * ub;
      6'h1a: begin
        if (b == 0) model = {a, 32'hFFFF_FFFF};
        else begin
          q = sa / sb;
          r = sa % sb;
          model = {r[31:0], q[31:0]};
        end
      end
      default: begin
        if (b == 0) model = {a, 32'hFFFF_FFFF};
        else model = {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] f, input logic [31:0] b);
    if ((f == 6'h1a || f == 6'h1b) && b == 0) return "R5 zero divisor";
    case (f)
      6'h18: return "R1 signed product";
      6'h19: return "R2 unsigned product";
      6'h1a: return "R3 signed quotient/remainder";
      default: return "R4 unsigned quotient/remainder";
    endcase
  endfunction

  task automatic read_hilo(output logic [31:0] hi, output logic [31:0] lo);
    @(negedge clk);
    rd_req = 1; rd_funct = 6'h10;
    #1 hi = rd_data;
    rd_funct = 6'h12;
    #1 lo = rd_data;
    rd_req = 0;
  endtask

  // Issue one command and wait for completion; meddle drives a second
  // command and a read request in the middle of the run.
  task automatic do_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input bit meddle);
    int n;
    logic [31:0] hi, lo;
    logic [63:0] e;
    @(negedge clk);
    cmd_valid = 1; cmd_funct = f; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (meddle && n == 2) begin
        cmd_valid = 1; cmd_funct = 6'h1b; cmd_a = ~a; cmd_b = 32'd7;
        rd_req = 1; rd_funct = 6'h12;
        #1;
        chk(rd_stall == 1'b1, "R8 stall while busy", {63'd0, rd_stall}, 64'd1);
        chk(cmd_ready == 1'b0, "R6 ready low while busy", {63'd0, cmd_ready}, 64'd0);
      end
      if (meddle && n == 3) begin
        cmd_valid = 0; rd_req = 0;
      end
      @(negedge clk);
    end
    chk(n == 33, "R6 busy length", 64'(n), 64'd33);
    read_hilo(hi, lo);
    e = model(f, a, b);
    chk({hi, lo} == e, meddle ? "R9 command while busy ignored" : tag_of(f, b), {hi, lo}, e);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] r;
    r = $urandom;
    case (r[2:0])
      3'd0: pick = 32'h0000_0000;
      3'd1: pick = 32'h8000_0000;
      3'd2: pick = 32'hFFFF_FFFF;
      3'd3: pick = {28'd0, r[31:28]};
      default: pick = $urandom;
    endcase
  endfunction

  initial begin
    logic [31:0] hi, lo;
    logic [5:0]  f;
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0, "R11 busy after reset", {63'd0, busy}, 64'd0);
    chk(cmd_ready == 1, "R11 ready after reset", {63'd0, cmd_ready}, 64'd1);
    read_hilo(hi, lo);
    chk({hi, lo} == 64'd0, "R11 Hi/Lo after reset", {hi, lo}, 64'd0);

    // Directed corners
    do_op(6'h18, 32'hFFFF_FFFD, 32'd7, 0);            // R1 -3*7
    do_op(6'h18, 32'h8000_0000, 32'h8000_0000, 0);    // R1
    do_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);    // R2
    do_op(6'h1a, 32'hFFFF_FFF9, 32'd2, 0);            // R3 -7/2
    do_op(6'h1a, 32'd7, 32'hFFFF_FFFE, 0);            // R3 7/-2
    do_op(6'h1a, 32'h8000_0000, 32'hFFFF_FFFF, 0);    // R3 overflow case
    do_op(6'h1b, 32'hFFFF_FFF9, 32'd2, 0);            // R4
    do_op(6'h1b, 32'h1234_5678, 32'd0, 0);            // R5 unsigned
    do_op(6'h1a, 32'hFFFF_FF00, 32'd0, 0);            // R5 signed negative
    do_op(6'h1a, 32'h8000_0000, 32'd0, 0);            // R5 most negative
    do_op(6'h18, 32'd3, 32'd5, 1);                    // R9 and R8

    // R8: stall clears once idle
    @(negedge clk);
    rd_req = 1; rd_funct = 6'h12;
    #1 chk(rd_stall == 0, "R8 no stall when idle", {63'd0, rd_stall}, 64'd0);
    // R7: Lo read, unknown selector reads zero
    chk(rd_data == 32'd15, "R7 read Lo", {32'd0, rd_data}, 64'd15);
    rd_funct = 6'h11;
    #1 chk(rd_data == 32'd0, "R7 other selector reads zero", {32'd0, rd_data}, 64'd0);
    rd_req = 0;

    // R10: unknown command code has no effect
    @(negedge clk);
    cmd_valid = 1; cmd_funct = 6'h20; cmd_a = 32'hDEAD_BEEF; cmd_b = 32'd3;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 0, "R10 unknown code keeps idle", {63'd0, busy}, 64'd0);
    repeat (3) @(negedge clk);
    read_hilo(hi, lo);
    chk({hi, lo} == 64'd15, "R10 Hi/Lo unchanged", {hi, lo}, 64'd15);
    // R7: values still held after idle cycles
    repeat (5) @(negedge clk);
    read_hilo(hi, lo);
    chk({hi, lo} == 64'd15, "R7 Hi/Lo held", {hi, lo}, 64'd15);

    // Constrained random mix
    for (int i = 0; i < 60; i++) begin
      f = 6'h18 + 6'($urandom_range(0, 3));
      do_op(f, pick(), pick(), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule